// File: doc/BRIEF.md
# Isochronous Resource Manager Lock Unit

This block holds the four shared resource registers that a node acting as isochronous resource manager offers to the rest of a serial bus: the bus manager identity, the pool of remaining isochronous bandwidth units and two 32-bit words that together form a 64-entry channel availability mask. Other nodes claim or return resources only through compare-swap lock requests. Each request carries a byte offset, an extended transaction code, an argument and new data. The unit answers with the old or agreed value and a response code. The bandwidth and channel registers do not use a plain whole-word compare. Bandwidth moves by the difference between argument and data, with range checks. Channel words toggle only the bits on which argument and data differ, and only if the register agrees with the argument on those bits. Channel 31 is held allocated at all times.

A single request port with a ready signal serialises all requesters. An accepted request is resolved completely in the cycle it is taken, and its response is presented one cycle later. A bus reset input restores every register to its power-up value and holds the port off while it is high.

Top module: `irm_lock_unit`

## Requirements
- R1: `reqReady` is high except while `busReset` is high. Every accepted request (`reqValid` and `reqReady` both high at a clock edge) yields `rspValid` for exactly one cycle after that edge. No response appears without an accepted request.
- R2: Response codes are 0 complete, 1 type error and 2 address error. A request whose offset is not a multiple of 4 returns type error. A request with an extended code other than 2 (compare-swap) changes nothing. It returns type error at a known offset (0x000 to 0x030) and address error elsewhere. `rspOld` is zero whenever the code is not complete.
- R3: The bus manager identity at offset 0x020 resets to 0x3F. A quadlet lock there returns the old value in `rspOld[31:0]` and stores the data only when the old value equals the argument.
- R4: The bandwidth register at offset 0x024 resets to 4915. A lock there whose argument exceeds 0x1FFF leaves it unchanged and returns the old value.
- R5: For a bandwidth lock, the data is first masked to its low 13 bits. If the argument is at least the masked data, the unit removes (argument − data) units, but only if that many remain. On success it returns the argument; on failure it returns the old value.
- R6: If the argument is below the masked data, the unit adds (data − argument) units, but only if the sum stays below 0x2000. On success it returns the argument; on failure it returns the old value.
- R7: A quadlet lock at 0x028 (channel word high) or 0x02C (channel word low) uses mask = argument XOR data. If the argument and the register agree on every bit of the mask, those bits are inverted and the argument is returned. Otherwise the register's current value is returned and the register is unchanged.
- R8: The high channel word resets to 0xFFFF_FFFE and the low word to 0xFFFF_FFFF. Bit 0 of the high word (channel 31) stays 0: the data of any lock on that word has that bit cleared before the rule is applied.
- R9: A lock with `reqWide` high is accepted only at offset 0x028. It applies the R7 rule to the 64-bit value {high word, low word}, with data bit 32 cleared first and bit 32 of the result forced to 0. A wide lock at any other offset returns type error at a known offset and address error elsewhere. A quadlet lock at any known offset other than 0x020 to 0x02C also returns type error.
- R10: While `busReset` is high, all four registers are reloaded with their reset values on every clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busReset | input | 1 | Synchronous bus reset: reloads registers and blocks requests |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request can be taken this cycle |
| reqAddr | input | 10 | Byte offset of the target register |
| reqExtCode | input | 4 | Extended transaction code (2 = compare-swap) |
| reqWide | input | 1 | 1 selects a 64-bit lock, 0 a quadlet lock |
| reqArg | input | 64 | Argument (quadlet locks use bits 31:0) |
| reqData | input | 64 | New data (quadlet locks use bits 31:0) |
| rspValid | output | 1 | Response present |
| rspOld | output | 64 | Old or agreed value |
| rspCode | output | 2 | Response code |

## Verification
Register state is never visible at the ports on its own. A corrupted register shows up only in the `rspOld` of the next lock that touches it. The bench therefore follows every sweep with a readback lock whose rule is sure to fail and so returns the current value. Examples are a bandwidth argument above 0x1FFF, or a wide lock whose mask includes the reserved channel bit. A wrong bandwidth delta, a wrong agreement test or a leaked channel 31 appears in the response of the very next access to that register, one cycle after acceptance. A wrong decode shows at once in `rspCode`.

// File: rtl/irm_lock_pkg.sv
package irm_lock_pkg;

  localparam logic [3:0] CAS_EXT = 4'd2;

  typedef enum logic [1:0] {
    RSP_COMPLETE = 2'd0,
    RSP_TYPE_ERR = 2'd1,
    RSP_ADDR_ERR = 2'd2
  } rsp_code_e;

  // strobes from decode to the datapath
  typedef struct packed {
    logic      accept;
    logic      reload;
    logic      selBm;
    logic      selBw;
    logic      selChHi;
    logic      selChLo;
    logic      selWide;
    rsp_code_e code;
  } lock_strobe_t;

endpackage

// File: rtl/irm_mask_cas.sv
// Masked compare-swap: only bits where arg and data differ are considered.
module irm_mask_cas #(
  parameter int W = 32
) (
  input  logic [W-1:0] curVal,
  input  logic [W-1:0] argVal,
  input  logic [W-1:0] dataVal,
  output logic         agree,
  output logic [W-1:0] nextVal,
  output logic [W-1:0] retVal
);
  logic [W-1:0] affected;

  always_comb begin
    affected = argVal ^ dataVal;
    agree    = ((argVal & affected) == (curVal & affected));
    nextVal  = curVal ^ affected;
    retVal   = agree ? argVal : curVal;
  end
endmodule

// File: rtl/irm_lock_ctrl.sv
module irm_lock_ctrl
  import irm_lock_pkg::*;
#(
  parameter int              ADDR_W     = 10,
  parameter int              EXT_W      = 4,
  parameter logic [ADDR_W-1:0] RES_BASE   = 'h020,
  parameter logic [ADDR_W-1:0] KNOWN_LAST = 'h030
) (
  input  logic              busReset,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [EXT_W-1:0]  reqExtCode,
  input  logic              reqWide,
  output logic              reqReady,
  output lock_strobe_t      strobes
);
  localparam logic [ADDR_W-1:0] OFF_BM = RES_BASE;
  localparam logic [ADDR_W-1:0] OFF_BW = RES_BASE + ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFF_HI = RES_BASE + ADDR_W'(8);
  localparam logic [ADDR_W-1:0] OFF_LO = RES_BASE + ADDR_W'(12);

  logic aligned, known, casOk, isBm, isBw, isHi, isLo, resHit, accept;
  rsp_code_e code;

  always_comb begin
    aligned = (reqAddr[1:0] == 2'b00);
    known   = (reqAddr <= KNOWN_LAST);
    casOk   = (reqExtCode == EXT_W'(CAS_EXT));
    isBm    = (reqAddr == OFF_BM);
    isBw    = (reqAddr == OFF_BW);
    isHi    = (reqAddr == OFF_HI);
    isLo    = (reqAddr == OFF_LO);
    resHit  = reqWide ? isHi : (isBm | isBw | isHi | isLo);

    if (!aligned)            code = RSP_TYPE_ERR;
    else if (casOk && resHit) code = RSP_COMPLETE;
    else if (known)          code = RSP_TYPE_ERR;
    else                     code = RSP_ADDR_ERR;

    reqReady = !busReset;
    accept   = reqValid && reqReady;

    strobes.accept  = accept;
    strobes.reload  = busReset;
    strobes.code    = code;
    strobes.selBm   = accept && (code == RSP_COMPLETE) && !reqWide && isBm;
    strobes.selBw   = accept && (code == RSP_COMPLETE) && !reqWide && isBw;
    strobes.selChHi = accept && (code == RSP_COMPLETE) && !reqWide && isHi;
    strobes.selChLo = accept && (code == RSP_COMPLETE) && !reqWide && isLo;
    strobes.selWide = accept && (code == RSP_COMPLETE) && reqWide;
  end
endmodule

// File: rtl/irm_lock_dp.sv
module irm_lock_dp
  import irm_lock_pkg::*;
#(
  parameter int            QW          = 32,
  parameter int            BW_W        = 13,
  parameter int            BW_RESET    = 4915,
  parameter logic [QW-1:0] BM_RESET    = 'h3F,
  parameter logic [QW-1:0] CH_HI_RESET = 'hFFFF_FFFE,
  parameter logic [QW-1:0] CH_LO_RESET = 'hFFFF_FFFF,
  parameter int            RSV_BIT     = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  lock_strobe_t      strobes,
  input  logic [2*QW-1:0]   reqArg,
  input  logic [2*QW-1:0]   reqData,
  output logic              rspValid,
  output logic [2*QW-1:0]   rspOld,
  output logic [1:0]        rspCode
);
  localparam int DW = 2 * QW;

  logic [QW-1:0]   bmReg, chHi, chLo;
  logic [BW_W-1:0] bwReg;

  logic [QW-1:0]   argQ, dataQ;
  assign argQ = reqArg[QW-1:0];

  // bandwidth arithmetic
  logic            argBig, allocDir, bwOk;
  logic [BW_W-1:0] argB, dMask, delta, bwNext;
  logic [BW_W:0]   bwSum;
  logic [QW-1:0]   bwRet;

  always_comb begin
    argBig   = |argQ[QW-1:BW_W];
    argB     = argQ[BW_W-1:0];
    dMask    = reqData[BW_W-1:0];
    allocDir = (argB >= dMask);
    delta    = allocDir ? (argB - dMask) : (dMask - argB);
    bwSum    = {1'b0, bwReg} + {1'b0, delta};
    bwOk     = !argBig && (allocDir ? (bwReg >= delta) : !bwSum[BW_W]);
    bwNext   = allocDir ? (bwReg - delta) : bwSum[BW_W-1:0];
    bwRet    = bwOk ? argQ : {{(QW-BW_W){1'b0}}, bwReg};
  end

  // quadlet channel word: hi and lo share one masked compare-swap
  logic [QW-1:0] curQ, nextQ, retQ;
  logic          agreeQ;

  always_comb begin
    curQ  = strobes.selChHi ? chHi : chLo;
    dataQ = reqData[QW-1:0];
    if (strobes.selChHi) dataQ[RSV_BIT] = 1'b0;
  end

  irm_mask_cas #(.W(QW)) u_casQ (
    .curVal(curQ), .argVal(argQ), .dataVal(dataQ),
    .agree(agreeQ), .nextVal(nextQ), .retVal(retQ)
  );

  // 64-bit channel lock over {hi, lo}
  logic [DW-1:0] curW, dataW, nextW, retW;
  logic          agreeW;

  always_comb begin
    curW  = {chHi, chLo};
    dataW = reqData;
    dataW[QW+RSV_BIT] = 1'b0;
  end

  irm_mask_cas #(.W(DW)) u_casW (
    .curVal(curW), .argVal(reqArg), .dataVal(dataW),
    .agree(agreeW), .nextVal(nextW), .retVal(retW)
  );

  // response value select
  logic [DW-1:0] retSel;
  always_comb begin
    retSel = '0;
    if (strobes.code == RSP_COMPLETE) begin
      if (strobes.selBm)                         retSel = {{QW{1'b0}}, bmReg};
      else if (strobes.selBw)                    retSel = {{QW{1'b0}}, bwRet};
      else if (strobes.selChHi || strobes.selChLo) retSel = {{QW{1'b0}}, retQ};
      else if (strobes.selWide)                  retSel = retW;
    end
  end

  // resource registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bmReg <= BM_RESET;
      bwReg <= BW_W'(BW_RESET);
      chHi  <= CH_HI_RESET;
      chLo  <= CH_LO_RESET;
    end else if (strobes.reload) begin
      bmReg <= BM_RESET;
      bwReg <= BW_W'(BW_RESET);
      chHi  <= CH_HI_RESET;
      chLo  <= CH_LO_RESET;
    end else begin
      if (strobes.selBm && (bmReg == argQ)) bmReg <= reqData[QW-1:0];
      if (strobes.selBw && bwOk)            bwReg <= bwNext;
      if (strobes.selChHi && agreeQ) begin
        chHi          <= nextQ;
        chHi[RSV_BIT] <= 1'b0;
      end
      if (strobes.selChLo && agreeQ)        chLo <= nextQ;
      if (strobes.selWide && agreeW) begin
        chHi          <= nextW[DW-1:QW];
        chHi[RSV_BIT] <= 1'b0;
        chLo          <= nextW[QW-1:0];
      end
    end
  end

  // response register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rspValid <= 1'b0;
      rspOld   <= '0;
      rspCode  <= 2'd0;
    end else begin
      rspValid <= strobes.accept;
      if (strobes.accept) begin
        rspOld  <= retSel;
        rspCode <= strobes.code;
      end
    end
  end
endmodule

// File: rtl/irm_lock_unit.sv
module irm_lock_unit
  import irm_lock_pkg::*;
#(
  parameter int              ADDR_W   = 10,
  parameter int              EXT_W    = 4,
  parameter int              QW       = 32,
  parameter int              BW_W     = 13,
  parameter int              BW_RESET = 4915,
  parameter logic [ADDR_W-1:0] RES_BASE = 'h020,
  parameter logic [ADDR_W-1:0] KNOWN_LAST = 'h030
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busReset,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [EXT_W-1:0]  reqExtCode,
  input  logic              reqWide,
  input  logic [2*QW-1:0]   reqArg,
  input  logic [2*QW-1:0]   reqData,
  output logic              rspValid,
  output logic [2*QW-1:0]   rspOld,
  output logic [1:0]        rspCode
);
  lock_strobe_t strobes;

  irm_lock_ctrl #(
    .ADDR_W(ADDR_W), .EXT_W(EXT_W), .RES_BASE(RES_BASE), .KNOWN_LAST(KNOWN_LAST)
  ) u_ctrl (
    .busReset(busReset), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqExtCode(reqExtCode), .reqWide(reqWide),
    .reqReady(reqReady), .strobes(strobes)
  );

  irm_lock_dp #(
    .QW(QW), .BW_W(BW_W), .BW_RESET(BW_RESET)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes),
    .reqArg(reqArg), .reqData(reqData),
    .rspValid(rspValid), .rspOld(rspOld), .rspCode(rspCode)
  );
endmodule

// File: rtl/irm_lock_chk.sv
module irm_lock_chk #(
  parameter int              ADDR_W   = 10,
  parameter int              EXT_W    = 4,
  parameter int              QW       = 32,
  parameter int              BW_W     = 13,
  parameter logic [ADDR_W-1:0] RES_BASE = 'h020
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busReset,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [EXT_W-1:0]  reqExtCode,
  input logic              reqWide,
  input logic [2*QW-1:0]   reqArg,
  input logic [2*QW-1:0]   reqData,
  input logic              rspValid,
  input logic [2*QW-1:0]   rspOld,
  input logic [1:0]        rspCode
);
  localparam logic [ADDR_W-1:0] OFF_BW = RES_BASE + ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFF_HI = RES_BASE + ADDR_W'(8);

  logic take;
  assign take = reqValid && reqReady;

  AST_NO_READY_IN_BUS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    busReset |-> !reqReady); // R1
  AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> rspValid); // R1
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> !rspValid); // R1
  AST_BAD_EXT_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (take && reqExtCode != EXT_W'(2)) |=> (rspCode != 2'd0 && rspOld == '0)); // R2
  AST_BW_RET_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (take && reqExtCode == EXT_W'(2) && !reqWide && reqAddr == OFF_BW)
      |=> (rspOld[2*QW-1:BW_W] == '0)); // R5
  AST_CH31_QUAD: assert property (@(posedge clk) disable iff (!rst_n)
    (take && reqExtCode == EXT_W'(2) && !reqWide && reqAddr == OFF_HI)
      |=> !rspOld[0]); // R8
  AST_CH31_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (take && reqExtCode == EXT_W'(2) && reqWide && reqAddr == OFF_HI)
      |=> !rspOld[QW]); // R9
endmodule

bind irm_lock_unit irm_lock_chk #(
  .ADDR_W(ADDR_W), .EXT_W(EXT_W), .QW(QW), .BW_W(BW_W), .RES_BASE(RES_BASE)
) u_chk (.*);

// File: tb/irm_lock_unit_test.sv
`timescale 1ns/1ps
module irm_lock_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        busReset = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [9:0]  reqAddr = '0;
  logic [3:0]  reqExtCode = '0;
  logic        reqWide = 1'b0;
  logic [63:0] reqArg = '0;
  logic [63:0] reqData = '0;
  logic        rspValid;
  logic [63:0] rspOld;
  logic [1:0]  rspCode;

  always #4 clk = ~clk;

  irm_lock_unit uut (
    .clk(clk), .rst_n(rst_n), .busReset(busReset),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .reqExtCode(reqExtCode), .reqWide(reqWide), .reqArg(reqArg),
    .reqData(reqData), .rspValid(rspValid), .rspOld(rspOld), .rspCode(rspCode)
  );

  int checks = 0;
  int errors = 0;

  // model of the resource registers
  logic [31:0] mBm;
  logic [31:0] mBw;
  logic [63:0] mCh;
  logic [31:0] lfsr = 32'h1234_5678;

  task automatic modelReset();
    mBm = 32'h3F;
    mBw = 32'd4915;
    mCh = 64'hFFFF_FFFE_FFFF_FFFF;
  endtask

  function automatic logic [31:0] nextRnd();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return lfsr;
  endfunction

  task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected outcome per the requirements; updates the model
  task automatic predict(input logic [9:0] a, input logic [3:0] ext, input logic wide,
                         input logic [63:0] arg, input logic [63:0] data,
                         output logic [1:0] code, output logic [63:0] old);
    logic known, hit;
    logic [63:0] aff, d64;
    logic [31:0] cur, dq, affq, n;
    known = (a <= 10'h030);
    hit   = wide ? (a == 10'h028) : (a >= 10'h020 && a <= 10'h02C);
    old   = '0;
    if (a[1:0] != 2'b00)       code = 2'd1;
    else if (ext == 4'd2 && hit) code = 2'd0;
    else if (known)            code = 2'd1;
    else                       code = 2'd2;
    if (code != 2'd0) return;
    if (wide) begin
      d64 = data; d64[32] = 1'b0;
      aff = arg ^ d64;
      if ((arg & aff) == (mCh & aff)) begin
        mCh = mCh ^ aff; old = arg;
      end else old = mCh;
      mCh[32] = 1'b0;
    end else if (a == 10'h020) begin
      old = {32'h0, mBm};
      if (mBm == arg[31:0]) mBm = data[31:0];
    end else if (a == 10'h024) begin
      old = {32'h0, mBw};
      dq = data[31:0] & 32'h1FFF;
      if (arg[31:0] <= 32'h1FFF) begin
        if (arg[31:0] >= dq) begin
          n = arg[31:0] - dq;
          if (mBw >= n) begin mBw = mBw - n; old = {32'h0, arg[31:0]}; end
        end else begin
          n = dq - arg[31:0];
          if (mBw + n < 32'h2000) begin mBw = mBw + n; old = {32'h0, arg[31:0]}; end
        end
      end
    end else begin
      cur = (a == 10'h028) ? mCh[63:32] : mCh[31:0];
      dq  = data[31:0];
      if (a == 10'h028) dq[0] = 1'b0;
      affq = arg[31:0] ^ dq;
      if ((arg[31:0] & affq) == (cur & affq)) begin
        cur = cur ^ affq; old = {32'h0, arg[31:0]};
      end else old = {32'h0, cur};
      if (a == 10'h028) begin cur[0] = 1'b0; mCh[63:32] = cur; end
      else mCh[31:0] = cur;
    end
  endtask

  task automatic doLock(input logic [9:0] a, input logic [3:0] ext, input logic wide,
                        input logic [63:0] arg, input logic [63:0] data, input string tag);
    logic [1:0] eCode;
    logic [63:0] eOld;
    @(negedge clk);
    reqAddr = a; reqExtCode = ext; reqWide = wide; reqArg = arg; reqData = data;
    reqValid = 1'b1;
    predict(a, ext, wide, arg, data, eCode, eOld);
    @(negedge clk);
    reqValid = 1'b0;
    check(rspValid === 1'b1, {tag, " R1 valid"}, {63'h0, rspValid}, 64'h1);
    check(rspCode === eCode, {tag, " code"}, {62'h0, rspCode}, {62'h0, eCode});
    check(rspOld === eOld, {tag, " old"}, rspOld, eOld);
  endtask

  task automatic readBack(input string tag);
    doLock(10'h020, 4'd2, 1'b0, 64'hFFFF_FFFF, 64'hFFFF_FFFF, {tag, " R3 bm"});
    doLock(10'h024, 4'd2, 1'b0, 64'h2000, 64'h0, {tag, " R4 bw"});
    doLock(10'h028, 4'd2, 1'b1, 64'h1_0000_0000, 64'h1_0000_0000, {tag, " R9 ch"});
  endtask

  logic [31:0] bwArgs [8] = '{32'h0, 32'h1, 32'd100, 32'd4915, 32'h1000, 32'h1FFF, 32'h2000, 32'h3000};
  logic [31:0] bwDats [6] = '{32'h0, 32'h5, 32'd2000, 32'h1FFF, 32'h1_2010, 32'h0FFF};

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(reqReady === 1'b1, "R1 ready after reset", {63'h0, reqReady}, 64'h1);
    check(rspValid === 1'b0, "R1 no response after reset", {63'h0, rspValid}, 64'h0);

    // reset values: R3, R4, R8
    readBack("reset");
    check(mCh == 64'hFFFF_FFFE_FFFF_FFFF && rspOld == mCh, "R8 channel reset", rspOld, 64'hFFFF_FFFE_FFFF_FFFF);

    // R1 single-cycle pulse
    @(negedge clk);
    check(rspValid === 1'b0, "R1 pulse one cycle", {63'h0, rspValid}, 64'h0);

    // R3 bus manager compare-swap
    doLock(10'h020, 4'd2, 1'b0, 64'h5, 64'h7, "R3 mismatch");
    doLock(10'h020, 4'd2, 1'b0, 64'h3F, 64'h12, "R3 match");
    doLock(10'h020, 4'd2, 1'b0, 64'h12, 64'h3F, "R3 restore");
    readBack("after R3");

    // R4/R5/R6 bandwidth sweep
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 6; j++) begin
        doLock(10'h024, 4'd2, 1'b0, {32'h0, bwArgs[i]}, {32'h0, bwDats[j]}, "R5 R6 bw sweep");
      end
      doLock(10'h024, 4'd2, 1'b0, 64'h2000, 64'h0, "R4 bw readback");
    end
    // exact-fit allocation and full return
    doLock(10'h024, 4'd2, 1'b0, {32'h0, mBw}, 64'h0, "R5 drain to zero");
    doLock(10'h024, 4'd2, 1'b0, 64'h1, 64'h0, "R5 empty pool refuses");
    doLock(10'h024, 4'd2, 1'b0, 64'h0, 64'h1FFF, "R6 refill to 0x1FFF");
    doLock(10'h024, 4'd2, 1'b0, 64'h0, 64'h1, "R6 overflow refused");
    readBack("after bw");

    // R7/R8 quadlet channel sweep
    for (int k = 0; k < 80; k++) begin
      logic [9:0] a;
      logic [31:0] cur, arg, data;
      a   = k[0] ? 10'h02C : 10'h028;
      cur = k[0] ? mCh[31:0] : mCh[63:32];
      arg = (k % 3 != 0) ? cur : nextRnd();
      data = arg ^ (nextRnd() & nextRnd() & nextRnd());
      if (k % 7 == 0 && !k[0]) data = arg | 32'h1;
      doLock(a, 4'd2, 1'b0, {32'h0, arg}, {32'h0, data}, "R7 R8 channel");
    end
    readBack("after chan");

    // R9 wide channel sweep
    for (int k = 0; k < 40; k++) begin
      logic [63:0] arg, data;
      arg  = (k % 2 == 0) ? mCh : {nextRnd(), nextRnd()};
      data = arg ^ {nextRnd() & nextRnd(), nextRnd() & nextRnd()};
      if (k % 5 == 0) data[32] = 1'b1;
      doLock(10'h028, 4'd2, 1'b1, arg, data, "R9 wide");
    end
    readBack("after wide");

    // R2 unsupported codes change nothing
    for (int e = 0; e < 16; e++) begin
      if (e != 2) begin
        doLock(10'h020, e[3:0], 1'b0, {32'h0, mBm}, 64'h55, "R2 bad ext bm");
        doLock(10'h024, e[3:0], 1'b0, 64'h0, 64'h100, "R2 bad ext bw");
        doLock(10'h028, e[3:0], 1'b1, mCh, ~mCh, "R2 bad ext wide");
        doLock(10'h100, e[3:0], 1'b0, 64'h0, 64'h0, "R2 bad ext far");
      end
    end
    readBack("after R2");

    // R2/R9 address decode sweep including misaligned offsets
    for (int a = 0; a < 72; a++) begin
      doLock(a[9:0], 4'd2, 1'b1, mCh, mCh, "R9 wide decode");
      doLock(a[9:0], 4'd2, 1'b0, {32'h0, nextRnd()}, {32'h0, nextRnd()}, "R2 quad decode");
    end
    readBack("after decode");

    // R10 bus reset reloads and R1 blocks requests
    doLock(10'h020, 4'd2, 1'b0, {32'h0, mBm}, 64'h9, "R10 setup bm");
    doLock(10'h024, 4'd2, 1'b0, 64'h10, 64'h0, "R10 setup bw");
    @(negedge clk);
    busReset = 1'b1;
    reqAddr = 10'h020; reqExtCode = 4'd2; reqWide = 1'b0;
    reqArg = 64'h3F; reqData = 64'h1;
    reqValid = 1'b1;
    #1;
    check(reqReady === 1'b0, "R1 ready low in bus reset", {63'h0, reqReady}, 64'h0);
    @(negedge clk);
    check(rspValid === 1'b0, "R1 no response in bus reset", {63'h0, rspValid}, 64'h0);
    @(negedge clk);
    reqValid = 1'b0;
    busReset = 1'b0;
    modelReset();
    #1;
    check(reqReady === 1'b1, "R1 ready after bus reset", {63'h0, reqReady}, 64'h1);
    readBack("R10 after bus reset");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule